// File: doc/BRIEF.md
# Radio Data Block Syndrome Checker

This block watches a serial radio-data bit stream that arrives with its own slow bit clock. Each time the bit clock rises, the newest bit joins a 26-bit sliding window: a 16-bit information word followed by a 10-bit check word. The block then rotates that window once all the way round. Each bit that leaves the top of the window goes into a 10-bit polynomial divider built on the generator x^10 + x^8 + x^7 + x^5 + x^4 + x^3 + 1. The resulting syndrome is looked up against the known offset syndromes. The block reports which block position (A, B, C, C', D or, when allowed, E) the window holds.

A controller uses the valid flag and the interrupt pulse to find block boundaries and to learn the position of a block inside its four-block group. For error correction the controller can freeze the window. Later bit-clock edges then only re-run the calculation on the held word and leave its contents unchanged. Per incoming bit, a sequencer driven by the system clock runs 28 steps: one shift step, 26 rotate steps and one end-of-calculation step. A bit-clock edge that arrives before those steps are done is flagged as an overrun.

Top module: `rds_syndrome_check`

## Requirements
- R1: The window W holds the latest 26 bits, with the newest bit at bit 0. The syndrome is S(x) = W(x)·x^-16 mod g(x), where bit i of W is the coefficient of x^i and g(x) = x^10+x^8+x^7+x^5+x^4+x^3+1. A valid block (message·x^10 + remainder + offset) therefore yields the syndrome of its offset.
- R2: Syndromes (bit 9 first) decode as follows: 1111011000 gives blk_code 010 (A); 1111010100 gives 001 (B); 1001011100 gives 100 (C); 1111001100 gives 000 (C'); 1001011000 gives 011 (D). Every other nonzero syndrome gives 111.
- R3: An all-zero syndrome gives blk_code 101 with syn_valid high only when e_enable is 1. When e_enable is 0 it gives 111 with syn_valid low.
- R4: syn_valid is high exactly when the last syndrome matched a table entry. syn_irq is a one-cycle pulse at each end of calculation that sets syn_valid.
- R5: blk_code and syn_valid update once per accepted bit-clock rising edge, no later than 32 system clocks after it. They hold their values until the next end of calculation.
- R6: While ecc_mode is 1, a bit-clock edge does not change the window. The calculation runs again on the held window and gives the same result.
- R7: A bit-clock rising edge that arrives while a calculation is still running is ignored, so no bit is shifted in. It sets overrun, which stays high until reset.
- R8: After reset the window is all zeros, blk_code is 111, and syn_valid, syn_irq and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_clk | input | 1 | Asynchronous serial bit clock; its rising edge takes in one bit |
| bit_in | input | 1 | Serial data bit, stable around the bit-clock rising edge |
| ecc_mode | input | 1 | Freezes the window contents (error-correction mode) |
| e_enable | input | 1 | Allows the all-zero syndrome to decode as offset E |
| blk_code | output | 3 | Block code of the last calculation |
| syn_valid | output | 1 | Last syndrome matched a table entry |
| syn_irq | output | 1 | One-cycle pulse when a calculation ends with a match |
| overrun | output | 1 | Sticky flag: a bit-clock edge arrived while busy |

## Verification
The bench uses the default 26-bit window and a two-stage synchroniser. The window width then matches the real code length, so proper codewords for every offset can be streamed in and each one must decode to its own position. Because a result is predicted after every bit, the windows that straddle two blocks and the all-zero window after reset are also checked. The short synchroniser keeps the 28-step calculation plus synchroniser latency inside a bit period of about forty system clocks. A second edge sent only eight clocks after the first falls well inside the busy window and exercises the overrun path.

// File: rtl/rds_syn_pkg.sv
package rds_syn_pkg;

  localparam int SYN_W = 10;
  // generator x^10+x^8+x^7+x^5+x^4+x^3+1
  localparam logic [SYN_W:0] GEN_POLY = 11'b101_1011_1001;

  typedef logic [SYN_W-1:0] syn_t;

  typedef enum logic [2:0] {
    CODE_CP   = 3'b000,
    CODE_B    = 3'b001,
    CODE_A    = 3'b010,
    CODE_D    = 3'b011,
    CODE_C    = 3'b100,
    CODE_E    = 3'b101,
    CODE_NONE = 3'b111
  } blk_code_e;

  // multiply by x modulo the generator
  function automatic syn_t mul_x(syn_t s);
    syn_t t;
    t = {s[SYN_W-2:0], 1'b0};
    if (s[SYN_W-1]) t = t ^ GEN_POLY[SYN_W-1:0];
    return t;
  endfunction

  // multiply by x^-1 modulo the generator
  function automatic syn_t div_x(syn_t s);
    logic [SYN_W:0] t;
    t = {1'b0, s};
    if (s[0]) t = t ^ GEN_POLY;
    return t[SYN_W:1];
  endfunction

  // x^-n modulo the generator
  function automatic syn_t inv_pow(int n);
    syn_t s;
    s = syn_t'(1);
    for (int i = 0; i < n; i++) s = div_x(s);
    return s;
  endfunction

  // returns {valid, code}
  function automatic logic [3:0] decode_syn(syn_t s, logic e_en);
    logic [3:0] r;
    case (s)
      10'b1111011000: r = {1'b1, CODE_A};
      10'b1111010100: r = {1'b1, CODE_B};
      10'b1001011100: r = {1'b1, CODE_C};
      10'b1111001100: r = {1'b1, CODE_CP};
      10'b1001011000: r = {1'b1, CODE_D};
      10'b0000000000: r = e_en ? {1'b1, CODE_E} : {1'b0, CODE_NONE};
      default:        r = {1'b0, CODE_NONE};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rds_bit_sync.sv
module rds_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rds_seq.sv
module rds_seq #(
  parameter int WIN_W = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic step_shift,
  output logic step_rot,
  output logic step_end,
  output logic overrun
);
  localparam int CW = $clog2(WIN_W + 2);
  localparam logic [CW-1:0] LAST = CW'(WIN_W + 1);

  logic          busy;
  logic [CW-1:0] cnt;

  assign step_shift = start & ~busy;
  assign step_rot   = busy & (cnt != LAST);
  assign step_end   = busy & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (step_shift) begin
      busy <= 1'b1;
      cnt  <= CW'(1);
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             overrun <= 1'b0;
    else if (start && busy) overrun <= 1'b1;
  end

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> overrun);
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R5
  end_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_end |=> !busy);
  // R5
  shift_then_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_shift |=> step_rot);
endmodule

// File: rtl/rds_win_div.sv
module rds_win_div
  import rds_syn_pkg::*;
#(
  parameter int WIN_W = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_shift,
  input  logic step_rot,
  input  logic freeze,
  input  logic bit_in,
  output syn_t syn
);
  localparam syn_t ROT_K = inv_pow(WIN_W - SYN_W);

  logic [WIN_W-1:0] win;
  logic             top_bit;

  assign top_bit = win[WIN_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
      syn <= '0;
    end else if (step_shift) begin
      if (!freeze) win <= {win[WIN_W-2:0], bit_in};
      syn <= '0;
    end else if (step_rot) begin
      win <= {win[WIN_W-2:0], top_bit};
      syn <= mul_x(syn) ^ (top_bit ? ROT_K : '0);
    end
  end

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_shift && freeze) |=> (win == $past(win)));
  // R1
  divider_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_shift |=> (syn == '0));
endmodule

// File: rtl/rds_syndrome_check.sv
module rds_syndrome_check #(
  parameter int WIN_W       = 26,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_clk,
  input  logic       bit_in,
  input  logic       ecc_mode,
  input  logic       e_enable,
  output logic [2:0] blk_code,
  output logic       syn_valid,
  output logic       syn_irq,
  output logic       overrun
);
  import rds_syn_pkg::*;

  logic       bit_rise;
  logic       step_shift;
  logic       step_rot;
  logic       step_end;
  syn_t       syn;
  logic [3:0] dec;

  rds_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (bit_clk),
    .rise_o   (bit_rise)
  );

  rds_seq #(.WIN_W(WIN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (bit_rise),
    .step_shift (step_shift),
    .step_rot   (step_rot),
    .step_end   (step_end),
    .overrun    (overrun)
  );

  rds_win_div #(.WIN_W(WIN_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_shift (step_shift),
    .step_rot   (step_rot),
    .freeze     (ecc_mode),
    .bit_in     (bit_in),
    .syn        (syn)
  );

  assign dec = decode_syn(syn, e_enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_code  <= CODE_NONE;
      syn_valid <= 1'b0;
      syn_irq   <= 1'b0;
    end else begin
      syn_irq <= step_end & dec[3];
      if (step_end) begin
        syn_valid <= dec[3];
        blk_code  <= dec[2:0];
      end
    end
  end

  // R4
  irq_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_irq |-> syn_valid);
  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syn_irq |=> !syn_irq);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_end |=> ($stable(blk_code) && $stable(syn_valid)));
  // R3
  zero_no_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_end && syn == '0 && !e_enable) |=> (!syn_valid && blk_code == 3'b111));
  // R2
  invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_valid |-> (blk_code == 3'b111));
endmodule

// File: tb/test_rds_syndrome_check.sv
module test_rds_syndrome_check;
  localparam int CLK_PERIOD = 10;
  localparam logic [10:0] GP = 11'b101_1011_1001;

  typedef struct {
    logic [2:0] code;
    logic       valid;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_clk = 1'b0;
  logic       bit_in = 1'b0;
  logic       ecc_mode = 1'b0;
  logic       e_enable = 1'b0;
  logic [2:0] blk_code;
  logic       syn_valid;
  logic       syn_irq;
  logic       overrun;

  int n_cmp = 0;
  int n_bad = 0;
  int irq_cnt = 0;
  int irq_seen = 0;
  logic [25:0] mwin = '0;
  item_t q[$];
  event cmp_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  rds_syndrome_check i_rds_syndrome_check (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .bit_in(bit_in),
    .ecc_mode(ecc_mode), .e_enable(e_enable), .blk_code(blk_code),
    .syn_valid(syn_valid), .syn_irq(syn_irq), .overrun(overrun)
  );

  always @(negedge clk) if (syn_irq) irq_cnt++;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // remainder of a 26-bit polynomial by the generator (long division)
  function automatic logic [9:0] b_rem(logic [25:0] w);
    logic [25:0] r;
    r = w;
    for (int i = 25; i >= 10; i--)
      if (r[i]) r = r ^ (26'(GP) << (i - 10));
    return r[9:0];
  endfunction

  // syndrome: remainder times x^-16
  function automatic logic [9:0] b_syn(logic [25:0] w);
    logic [10:0] t;
    t = {1'b0, b_rem(w)};
    for (int k = 0; k < 16; k++) begin
      if (t[0]) t = t ^ GP;
      t = t >> 1;
    end
    return t[9:0];
  endfunction

  function automatic item_t b_expect(logic [9:0] s, logic een);
    item_t it;
    it.valid = 1'b1;
    case (s)
      10'b1111011000: it.code = 3'b010;
      10'b1111010100: it.code = 3'b001;
      10'b1001011100: it.code = 3'b100;
      10'b1111001100: it.code = 3'b000;
      10'b1001011000: it.code = 3'b011;
      default: begin
        if (s == 10'd0 && een) it.code = 3'b101;
        else begin it.code = 3'b111; it.valid = 1'b0; end
      end
    endcase
    return it;
  endfunction

  task automatic send_bit(input logic b);
    bit_in = b;
    repeat (2) @(negedge clk);
    bit_clk = 1'b1;
    if (!ecc_mode) mwin = {mwin[24:0], b};
    q.push_back(b_expect(b_syn(mwin), e_enable));
    repeat (4) @(negedge clk);
    bit_clk = 1'b0;
    repeat (36) @(negedge clk);
    ->cmp_ev;
    @(negedge clk);
  endtask

  task automatic send_block(input logic [15:0] m, input logic [9:0] off);
    logic [25:0] cw;
    cw = {m, b_rem({m, 10'd0}) ^ off};
    for (int i = 25; i >= 0; i--) send_bit(cw[i]);
  endtask

  // monitor: scoreboard compare
  initial begin
    forever begin
      @(cmp_ev);
      if (q.size() == 0) begin
        chk(1'b0, "R5 queue", 0, 1);
      end else begin
        item_t e;
        e = q.pop_front();
        chk(blk_code == e.code, "R1/R2 code", int'(blk_code), int'(e.code));
        chk(syn_valid == e.valid, "R4 valid", int'(syn_valid), int'(e.valid));
        chk((irq_cnt - irq_seen) == int'(e.valid), "R4 irq", irq_cnt - irq_seen, int'(e.valid));
        irq_seen = irq_cnt;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] hold_code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk(blk_code == 3'b111, "R8 code", int'(blk_code), 7);
    chk(syn_valid == 1'b0, "R8 valid", int'(syn_valid), 0);
    chk(syn_irq == 1'b0, "R8 irq", int'(syn_irq), 0);
    chk(overrun == 1'b0, "R8 overrun", int'(overrun), 0);

    // R3 zero window without and with E enabled
    e_enable = 1'b0;
    send_bit(1'b0);
    chk(blk_code == 3'b111 && !syn_valid, "R3 E off", int'(blk_code), 7);
    e_enable = 1'b1;
    send_bit(1'b0);
    chk(blk_code == 3'b101 && syn_valid, "R3 E on", int'(blk_code), 5);

    // R5 hold between calculations
    hold_code = blk_code;
    repeat (50) @(negedge clk);
    chk(blk_code == hold_code && syn_valid, "R5 hold", int'(blk_code), int'(hold_code));

    // R7 overrun: second edge during busy is ignored
    bit_in = 1'b0;
    repeat (2) @(negedge clk);
    bit_clk = 1'b1;
    mwin = {mwin[24:0], 1'b0};
    q.push_back(b_expect(b_syn(mwin), e_enable));
    repeat (4) @(negedge clk);
    bit_clk = 1'b0;
    bit_in = 1'b1;
    repeat (4) @(negedge clk);
    bit_clk = 1'b1;
    repeat (4) @(negedge clk);
    bit_clk = 1'b0;
    repeat (40) @(negedge clk);
    ->cmp_ev;
    @(negedge clk);
    chk(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
    chk(blk_code == 3'b101, "R7 edge ignored", int'(blk_code), 5);
    send_bit(1'b0);
    chk(overrun == 1'b1, "R7 sticky", int'(overrun), 1);

    // restart
    rst_n = 1'b0;
    mwin = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(overrun == 1'b0, "R8 overrun cleared", int'(overrun), 0);
    e_enable = 1'b0;

    // R1 R2 proper blocks for each offset
    send_block(16'h1234, 10'b0011111100);
    chk(blk_code == 3'b010, "R2 A", int'(blk_code), 2);
    send_block(16'hBEEF, 10'b0110011000);
    chk(blk_code == 3'b001, "R2 B", int'(blk_code), 1);
    send_block(16'h0F0F, 10'b0101101000);
    chk(blk_code == 3'b100, "R2 C", int'(blk_code), 4);
    send_block(16'hA5C3, 10'b1101010000);
    chk(blk_code == 3'b000, "R2 Cp", int'(blk_code), 0);
    send_block(16'h7E01, 10'b0110110100);
    chk(blk_code == 3'b011, "R2 D", int'(blk_code), 3);

    // R6 frozen window keeps decoding D
    ecc_mode = 1'b1;
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    chk(blk_code == 3'b011 && syn_valid, "R6 frozen", int'(blk_code), 3);
    ecc_mode = 1'b0;
    send_bit(1'b1);

    // R2 corrupted block decodes as none
    begin
      logic [25:0] cw;
      cw = {16'h4321, b_rem({16'h4321, 10'd0}) ^ 10'b0011111100};
      cw[13] = ~cw[13];
      for (int i = 25; i >= 0; i--) send_bit(cw[i]);
      chk(blk_code == 3'b111 && !syn_valid, "R2 corrupt", int'(blk_code), 7);
    end

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule